// File: doc/BRIEF.md
# Packet-Gated Transmit Release Controller

This block sits between the last transmit packet FIFO and a 10G Ethernet MAC. A MAC of this kind must not be starved in the middle of a frame. The block therefore holds the FIFO's read side closed until it is safe to start a frame. It counts the complete packets held in the FIFO by watching tlast handshakes on the FIFO's write side and on its read side. Reads open when at least one whole packet is buffered and the transmit enable is on.

An optional cut-through mode, selected by a nonzero `CUT_THRESH`, lets a frame start before its end has been written. It does so once the FIFO occupancy rises strictly above the threshold, and it keeps the read side open until the MAC takes an end-of-frame. The transmit enable arrives from another clock domain and passes through a synchronizer whose flops reset to 1. The FIFO read ready, the MAC valid and the MAC start-of-frame are all gated by one release condition. The data path itself bypasses the block.

The release state machine has three states. HOLD releases only when a whole packet is available. FRAME is a frame in progress on the packet-count path, and release is forced on. CUT is cut-through active, and release is also forced on. Transitions:
- **take-frame** (HOLD→FRAME): release is on and a non-last beat is read.
- **frame-done** (FRAME→HOLD): the tlast beat is read.
- **cut-enter** (HOLD or FRAME→CUT): the occupancy is above the threshold.
- **cut-exit** (CUT→HOLD): an end-of-frame beat reaches the MAC while the occupancy is not above the threshold.

Top module: `tx_release_ctrl`

## Requirements
- R1: While in HOLD, with a packet count of zero or a synchronized enable of 0, `fifo_ready`, `mac_valid` and `mac_sof` are all 0, whatever `fifo_valid` is.
- R2: `fifo_ready` equals the release condition. `mac_valid` is `fifo_valid` AND release, and `mac_sof` is `fifo_sof` AND `fifo_valid` AND release.
- R3: When `CUT_THRESH` > 0 and `occupancy` > `CUT_THRESH` (strictly), release is 1 from the next cycle on. Occupancy equal to the threshold does not start cut-through.
- R4: The packet count rises by one on a write tlast handshake (`wr_valid`&`wr_ready`&`wr_last`) and falls by one on a read tlast handshake (`fifo_valid`&`fifo_ready`&`fifo_last`). Both in one cycle leave it unchanged. It saturates at 0 and at 2^`CNT_W`-1.
- R5: Once a non-last beat has been read, release stays 1 until the tlast beat of that frame is read, even if the count or the enable drops.
- R6: In CUT, a cycle with `mac_valid`&`fifo_last` returns the block to HOLD, unless the occupancy is above the threshold in that same cycle, in which case CUT holds.
- R7: With `CUT_THRESH` = 0, the occupancy has no effect and the block never enters CUT.
- R8: `tx_enable` passes through 3 flops. A change is seen by the release logic 3 cycles later, and the flops reset to 1.
- R9: Reset puts the block in HOLD with a packet count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable from another clock domain |
| wr_valid | input | 1 | FIFO write-side valid |
| wr_ready | input | 1 | FIFO write-side ready |
| wr_last | input | 1 | FIFO write-side tlast |
| occupancy | input | OCC_W | FIFO occupancy in words |
| fifo_valid | input | 1 | FIFO read-side valid |
| fifo_sof | input | 1 | Start-of-frame flag stored with the read beat |
| fifo_last | input | 1 | FIFO read-side tlast |
| fifo_ready | output | 1 | FIFO read ready (release) |
| mac_valid | output | 1 | Gated valid to the MAC |
| mac_sof | output | 1 | Gated start-of-frame to the MAC |

## Verification
Two pairs of events can fall in one cycle. The first is a write tlast and a read tlast, which must leave the count unchanged. The second is a cut-through end-of-frame together with an occupancy still above the threshold, which must keep CUT. Directed steps drive each pair deliberately. Seeded random traffic then biases the occupancy around the threshold and fires both tlast kinds often. Every cycle, a bench model of the count, the synchronizer and the state predicts the three outputs of a cut-through instance and of a non-cut-through instance.

// File: rtl/tx_rel_pkg.sv
package tx_rel_pkg;
    typedef enum logic [1:0] {
        REL_HOLD  = 2'd0,
        REL_FRAME = 2'd1,
        REL_CUT   = 2'd2
    } rel_state_e;
endpackage

// File: rtl/tx_rel_sync.sv
module tx_rel_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/tx_rel_pkt_count.sv
module tx_rel_pkt_count #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign nonzero = (cnt_q != '0);

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
        (cnt_q == $past(cnt_q) - 1'b1));

    assert_both_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/tx_rel_fsm.sv
module tx_rel_fsm
    import tx_rel_pkg::*;
#(
    parameter bit CUT_EN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic pkt_avail,
    input  logic cut_start,
    input  logic fifo_valid,
    input  logic fifo_last,
    output logic release_o
);
    rel_state_e state_q, state_d;
    logic       beat_last;
    logic       beat_more;

    assign beat_last = fifo_valid && fifo_last;
    assign beat_more = fifo_valid && !fifo_last;

    always_ff @(posedge clk) begin
        if (rst) state_q <= REL_HOLD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REL_HOLD: begin
                if (cut_start)                   state_d = REL_CUT;
                else if (pkt_avail && beat_more) state_d = REL_FRAME;
            end
            REL_FRAME: begin
                if (cut_start)      state_d = REL_CUT;
                else if (beat_last) state_d = REL_HOLD;
            end
            REL_CUT: begin
                if (!cut_start && beat_last) state_d = REL_HOLD;
            end
            default: state_d = REL_HOLD;
        endcase
    end

    always_comb begin
        unique case (state_q)
            REL_HOLD:  release_o = pkt_avail;
            REL_FRAME: release_o = 1'b1;
            REL_CUT:   release_o = 1'b1;
            default:   release_o = 1'b0;
        endcase
    end

    assert_frame_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q != REL_HOLD && !beat_last) |=> release_o);

    assert_cut_open_R3: assert property (@(posedge clk) disable iff (rst)
        cut_start |=> release_o);

    generate
        if (!CUT_EN) begin : g_nocut_chk
            assert_no_cut_R7: assert property (@(posedge clk) disable iff (rst)
                state_q != REL_CUT);
        end
    endgenerate
endmodule

// File: rtl/tx_release_ctrl.sv
module tx_release_ctrl #(
    parameter int OCC_W       = 11,
    parameter int CNT_W       = 8,
    parameter int CUT_THRESH  = 0,
    parameter int SYNC_STAGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_enable,
    input  logic             wr_valid,
    input  logic             wr_ready,
    input  logic             wr_last,
    input  logic [OCC_W-1:0] occupancy,
    input  logic             fifo_valid,
    input  logic             fifo_sof,
    input  logic             fifo_last,
    output logic             fifo_ready,
    output logic             mac_valid,
    output logic             mac_sof
);
    localparam bit               CUT_EN = (CUT_THRESH > 0);
    localparam logic [OCC_W-1:0] THR_L  = OCC_W'(CUT_THRESH);

    logic en_sync;
    logic pkt_nonzero;
    logic cut_start;
    logic release_w;
    logic wr_tlast_fire;
    logic rd_tlast_fire;

    tx_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(tx_enable), .d_out(en_sync)
    );

    assign wr_tlast_fire = wr_valid && wr_ready && wr_last;
    assign rd_tlast_fire = fifo_valid && fifo_ready && fifo_last;

    tx_rel_pkt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .inc(wr_tlast_fire), .dec(rd_tlast_fire),
        .nonzero(pkt_nonzero)
    );

    generate
        if (CUT_EN) begin : g_cut
            assign cut_start = (occupancy > THR_L);
        end else begin : g_nocut
            assign cut_start = 1'b0;
        end
    endgenerate

    tx_rel_fsm #(.CUT_EN(CUT_EN)) u_fsm (
        .clk(clk), .rst(rst),
        .pkt_avail(pkt_nonzero && en_sync),
        .cut_start(cut_start),
        .fifo_valid(fifo_valid),
        .fifo_last(fifo_last),
        .release_o(release_w)
    );

    assign fifo_ready = release_w;
    assign mac_valid  = fifo_valid && release_w;
    assign mac_sof    = fifo_sof && fifo_valid && release_w;

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        mac_valid |-> (fifo_ready && fifo_valid));

    assert_sof_R2: assert property (@(posedge clk) disable iff (rst)
        mac_sof |-> mac_valid);

    generate
        if (SYNC_STAGES == 3) begin : g_sync_chk
            assert_sync_lag_R8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst, 3)) |-> (en_sync == $past(tx_enable, 3)));
        end
    endgenerate
endmodule

// File: tb/tb_tx_release_ctrl.sv
module tb_tx_release_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int OCC_W      = 11;
    localparam int THR        = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_enable = 1'b1;
    logic wr_valid = 1'b0, wr_ready = 1'b0, wr_last = 1'b0;
    logic [OCC_W-1:0] occupancy = '0;
    logic fifo_valid = 1'b0, fifo_sof = 1'b0, fifo_last = 1'b0;
    logic rdy [2];
    logic mv  [2];
    logic ms  [2];

    int checks = 0;
    int failures = 0;

    int       m_state [2];
    int       m_cnt   [2];
    logic [2:0] m_sync;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_release_ctrl #(.OCC_W(OCC_W), .CNT_W(3), .CUT_THRESH(THR)) dut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_last(wr_last),
        .occupancy(occupancy), .fifo_valid(fifo_valid), .fifo_sof(fifo_sof),
        .fifo_last(fifo_last), .fifo_ready(rdy[0]), .mac_valid(mv[0]), .mac_sof(ms[0])
    );

    tx_release_ctrl #(.OCC_W(OCC_W), .CNT_W(3), .CUT_THRESH(0)) dut_nc (
        .clk(clk), .rst(rst), .tx_enable(tx_enable),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_last(wr_last),
        .occupancy(occupancy), .fifo_valid(fifo_valid), .fifo_sof(fifo_sof),
        .fifo_last(fifo_last), .fifo_ready(rdy[1]), .mac_valid(mv[1]), .mac_sof(ms[1])
    );

    function automatic logic exp_rel(int i);
        return (m_state[i] != 0) || ((m_cnt[i] != 0) && m_sync[2]);
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare both instances, then advance the model.
    task automatic step(logic wv, logic wr, logic wl, int occ, logic fv, logic fs,
                        logic fl, logic en, string req);
        @(negedge clk);
        wr_valid = wv; wr_ready = wr; wr_last = wl; occupancy = OCC_W'(occ);
        fifo_valid = fv; fifo_sof = fs; fifo_last = fl; tx_enable = en;
        #1;
        for (int i = 0; i < 2; i++) begin
            logic rel;
            logic cs;
            string tag;
            rel = exp_rel(i);
            tag = (i == 1) ? "R7" : req;
            if (!rst) begin
                check(tag, "fifo_ready", rdy[i], rel);
                check(tag, "mac_valid", mv[i], rel && fv);
                check(tag, "mac_sof", ms[i], rel && fv && fs);
            end
            cs = (i == 0) && (occ > THR);
            if (rst) begin
                m_state[i] = 0; m_cnt[i] = 0;
            end else begin
                if ((wv && wr && wl) && !(fv && rel && fl)) begin
                    if (m_cnt[i] != 7) m_cnt[i]++;
                end else if (!(wv && wr && wl) && (fv && rel && fl)) begin
                    if (m_cnt[i] != 0) m_cnt[i]--;
                end
                case (m_state[i])
                    0: if (cs) m_state[i] = 2;
                       else if (rel && fv && !fl) m_state[i] = 1;
                    1: if (cs) m_state[i] = 2;
                       else if (fv && fl) m_state[i] = 0;
                    default: if (!cs && fv && fl) m_state[i] = 0;
                endcase
            end
        end
        m_sync = rst ? 3'b111 : {m_sync[1:0], en};
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_sync = 3'b111;
        m_state[0] = 0; m_state[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        rst = 1'b1;
        repeat (5) step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        rst = 1'b0;
        // R9: after reset, closed with no packet
        step(0, 0, 0, 0, 1, 1, 0, 1, "R9");
        // R1: data without a whole packet stays held
        repeat (3) step(0, 1, 0, 5, 1, 1, 0, 1, "R1");
        // R4: one packet written, then read start
        step(1, 1, 1, 5, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 5, 1, 1, 0, 1, "R4");
        // R4: write tlast and read tlast together keep count at 1
        step(1, 1, 1, 5, 1, 0, 1, 1, "R4");
        step(0, 0, 0, 5, 1, 1, 0, 1, "R4");
        // R5: enable drops mid-frame, release holds until tlast
        repeat (5) step(0, 0, 0, 5, 1, 0, 0, 0, "R5");
        step(0, 0, 0, 5, 1, 0, 1, 0, "R5");
        // R8: enable off, packet present, still held until enable returns 3 cycles later
        step(1, 1, 1, 5, 0, 0, 0, 0, "R8");
        repeat (3) step(0, 0, 0, 5, 1, 1, 0, 1, "R8");
        step(0, 0, 0, 5, 1, 0, 1, 1, "R8");
        // R3: occupancy equal to threshold does not cut; above does
        step(0, 0, 0, THR, 1, 1, 0, 0, "R3");
        step(0, 0, 0, THR + 1, 1, 1, 0, 0, "R3");
        step(0, 0, 0, 3, 1, 0, 0, 0, "R3");
        // R6: end-of-frame while still above threshold keeps cut; then exits
        step(0, 0, 0, THR + 4, 1, 0, 1, 0, "R6");
        step(0, 0, 0, 2, 1, 0, 1, 0, "R6");
        step(0, 0, 0, 2, 1, 1, 0, 0, "R6");
        // random traffic around the threshold
        for (int n = 0; n < 3000; n++) begin
            logic en_r;
            en_r = ($urandom_range(0, 19) != 0);
            step($urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, THR + 6), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 1), $urandom_range(0, 3) == 0, en_r, "R2");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule